// File: doc/BRIEF.md
# Subcode Q Serial Readout Port

This block keeps one decoded subcode Q frame of 80 bits and hands it to an external controller over a slow serial link. Upstream decode logic presents each frame with a load strobe and a CRC-pass flag. The block decides whether the frame is worth announcing. If it is, it raises `ready`. The controller then clocks the bits out on `shift_clk`, least significant bit first, and ends the transfer with a `read_done` pulse.

An announced frame is not held forever. If no read begins within a fixed window of `HOLD_CYCLES` system clocks, `ready` falls again. A command byte selects one of two gating modes. In address-1 mode a frame qualifies only when its CRC passed and its address-mode field is 1. In address-free mode the CRC result alone decides. From the first accepted shift edge until `read_done`, the register is frozen and incoming frames are dropped. The serial output is driven only while chip select is low.

The controller is a three-state machine:

- `ST_WAIT`: `ready` is low and frames are accepted.
- `ST_READY`: `ready` is high, frames are accepted and the hold timer runs.
  - `WAIT→READY` happens on a qualifying load.
  - `READY→READY` happens on a qualifying reload, which restarts the timer.
  - `READY→WAIT` happens on `read_done`, on a non-qualifying load, or on timer expiry.
- `ST_READ`: `ready` is high, the register is frozen and the timer is stopped.
  - `READY→READ` happens on the first shift edge.
  - `READ→WAIT` happens on `read_done`.

Top module: `subq_readout`

## Requirements
- R1: After reset, `ready` is low and the block is in address-1 mode.
- R2: A `frame_load` in `ST_WAIT` or `ST_READY` captures `frame_in`. In address-1 mode, `ready` is high in the following cycle exactly when `crc_ok` was high and `frame_in[7:4]` equals 1. A load that does not qualify leaves or sets `ready` low.
- R3: A `cmd_stb` with byte 0x89 selects address-free mode, in which `frame_in[7:4]` is ignored and `crc_ok` alone qualifies a frame. A strobe with byte 0x09 restores address-1 mode. Any other byte leaves the mode unchanged.
- R4: The frame layout is fixed:
  - `frame_in[3:0]` holds CONT and `frame_in[7:4]` holds ADR.
  - The following bytes hold, in order: TNO, INDEX, MIN, SEC, FRAME, ZERO, AMIN, ASEC, AFRAME.
  - After k accepted shift edges, `sdo` shows `frame_in[k]` of the captured frame, so bit 0 is visible before the first edge.
- R5: `shift_clk` passes through a two-flop synchronizer, and a shift takes place on its rising edge. A rising edge is ignored while `ready` is low or while `cs_n` is high.
- R6: From the first accepted shift edge until `read_done`, frame loads are dropped rather than queued, `ready` stays high and the hold timer does not expire.
- R7: A `read_done` pulse makes `ready` low in the next cycle and re-enables frame capture.
- R8: With no read started, `ready` is high for exactly `HOLD_CYCLES` cycles after a qualifying load and then falls. A further qualifying load restarts that window.
- R9: `sdo_oe` is high exactly when `cs_n` is low, and `sdo` is 0 while `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_in | input | 80 | Decoded subcode Q frame |
| frame_load | input | 1 | One-cycle strobe presenting `frame_in` |
| crc_ok | input | 1 | CRC-pass flag valid with `frame_load` |
| cmd_byte | input | 8 | Command byte |
| cmd_stb | input | 1 | One-cycle strobe for `cmd_byte` |
| shift_clk | input | 1 | Asynchronous serial shift clock from the controller |
| read_done | input | 1 | One-cycle read-complete pulse |
| cs_n | input | 1 | Active-low chip select |
| ready | output | 1 | Frame available for reading |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for `sdo` (high drives, low means high impedance) |

## Verification
The assertions assume the following about the inputs:
- `frame_load`, `cmd_stb` and `read_done` are single-cycle strobes that change only away from the clock edge.
- `shift_clk` stays at each level for several system cycles, so the edge detector sees every transition.

The stimulus honours these assumptions in several ways:
- It drives all inputs on the falling clock edge.
- It holds each `shift_clk` level for three cycles.
- In the random phase it never issues a load together with a shift edge or a `read_done`.

// File: rtl/subq_pkg.sv
package subq_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_READY = 2'd1,
        ST_READ  = 2'd2
    } rd_state_t;

    localparam logic [7:0] CMD_ADDR_FREE = 8'h89;
    localparam logic [7:0] CMD_ADDR_ONE  = 8'h09;
    localparam int         ADR_LSB       = 4;
    localparam int         ADR_W         = 4;
    localparam logic [3:0] ADR_MODE_ONE  = 4'd1;
endpackage

// File: rtl/subq_edge_sync.sv
module subq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/subq_shifter.sv
module subq_shifter #(
    parameter int W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         bit_out
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= din;
        else if (shift) sreg <= {1'b0, sreg[W-1:1]};
    end

    assign bit_out = sreg[0];

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sreg));
endmodule

// File: rtl/subq_hold_timer.sv
module subq_hold_timer #(
    parameter int HOLD = 189_665
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart)          cnt <= '0;
        else if (run && !expired)  cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/subq_readout.sv
module subq_readout
    import subq_pkg::*;
#(
    parameter int FRAME_W     = 80,
    parameter int HOLD_CYCLES = 189_665,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               frame_load,
    input  logic               crc_ok,
    input  logic [7:0]         cmd_byte,
    input  logic               cmd_stb,
    input  logic               shift_clk,
    input  logic               read_done,
    input  logic               cs_n,
    output logic               ready,
    output logic               sdo,
    output logic               sdo_oe
);
    rd_state_t state, state_nx;
    logic      addr_free;
    logic      sclk_rise, shift_ev, shift_do;
    logic      cap, qual, restart, expired, ser_bit;

    subq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(shift_clk), .rise(sclk_rise)
    );

    assign shift_ev = sclk_rise & ~cs_n;
    assign shift_do = shift_ev & (state != ST_WAIT);
    assign qual     = crc_ok &
                      (addr_free || frame_in[ADR_LSB +: ADR_W] == ADR_MODE_ONE);
    assign cap      = frame_load &
                      ((state == ST_WAIT) ||
                       (state == ST_READY && !shift_ev && !read_done));
    assign restart  = cap & qual;

    subq_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(cap), .din(frame_in),
        .shift(shift_do), .bit_out(ser_bit)
    );

    subq_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .run(state == ST_READY), .expired(expired)
    );

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n) addr_free <= 1'b0;
        else if (cmd_stb) begin
            if (cmd_byte == CMD_ADDR_FREE)     addr_free <= 1'b1;
            else if (cmd_byte == CMD_ADDR_ONE) addr_free <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (cap && qual) state_nx = ST_READY;
            ST_READY: begin
                if (read_done)     state_nx = ST_WAIT;
                else if (shift_ev) state_nx = ST_READ;
                else if (cap)      state_nx = qual ? ST_READY : ST_WAIT;
                else if (expired)  state_nx = ST_WAIT;
            end
            ST_READ:  if (read_done) state_nx = ST_WAIT;
            default:  state_nx = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        ready  = (state != ST_WAIT);
        sdo_oe = ~cs_n;
        sdo    = sdo_oe & ser_bit;
    end

    // R2
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(frame_load && crc_ok));

    // R7
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_done |=> !ready);

    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !read_done) |=> (state == ST_READ && ready));

    // R3
    mode_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_byte == CMD_ADDR_FREE) |=> addr_free);
endmodule

// File: tb/tb_subq_readout.sv
module tb_subq_readout;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] frame_in = '0;
    logic        frame_load = 1'b0, crc_ok = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        cmd_stb = 1'b0, shift_clk = 1'b0, read_done = 1'b0, cs_n = 1'b0;
    logic        ready, sdo, sdo_oe;

    int checks = 0, fails = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    subq_readout #(.HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .frame_load(frame_load),
        .crc_ok(crc_ok), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb),
        .shift_clk(shift_clk), .read_done(read_done), .cs_n(cs_n),
        .ready(ready), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [79:0] mk(logic [3:0] adr);
        logic [79:0] f;
        f[31:0]  = $urandom;
        f[63:32] = $urandom;
        f[79:64] = 16'($urandom);
        f[7:4]   = adr;
        return f;
    endfunction

    function automatic bit qualifies(logic [79:0] f, bit crc, bit free_mode);
        return crc && (free_mode || f[7:4] == 4'd1);
    endfunction

    task automatic load(logic [79:0] f, bit crc);
        frame_in = f; crc_ok = crc; frame_load = 1'b1;
        @(negedge clk);
        frame_load = 1'b0; crc_ok = 1'b0;
    endtask

    task automatic cmd(logic [7:0] b);
        cmd_byte = b; cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic pulse_shift();
        shift_clk = 1'b1;
        repeat (3) @(negedge clk);
        shift_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic done();
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
    endtask

    task automatic read80(output logic [79:0] got, input bit inject,
                          input logic [79:0] inj);
        for (int i = 0; i < 80; i++) begin
            got[i] = sdo;
            shift_clk = 1'b1;
            repeat (3) @(negedge clk);
            shift_clk = 1'b0;
            if (inject && i == 10) load(inj, 1'b1);
            else @(negedge clk);
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [79:0] f, g, got;
        bit free_mode, crc;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", 80'(ready), 80'd0);
        f = mk(4'd5);
        load(f, 1'b1);
        chk("R1 address-1 mode after reset", 80'(ready), 80'd0);

        // R2 gating in address-1 mode
        f = mk(4'd1);
        load(f, 1'b1);
        chk("R2 ADR=1 CRC ok", 80'(ready), 80'd1);
        load(mk(4'd1), 1'b0);
        chk("R2 CRC fail drops ready", 80'(ready), 80'd0);
        load(mk(4'd2), 1'b1);
        chk("R2 ADR=2 rejected", 80'(ready), 80'd0);

        // R3 mode commands
        cmd(8'h89);
        load(mk(4'd7), 1'b1);
        chk("R3 address-free accepts ADR=7", 80'(ready), 80'd1);
        done();
        cmd(8'h55);
        load(mk(4'd3), 1'b1);
        chk("R3 other byte keeps free mode", 80'(ready), 80'd1);
        load(mk(4'd3), 1'b0);
        chk("R3 free mode still needs CRC", 80'(ready), 80'd0);
        cmd(8'h09);
        load(mk(4'd3), 1'b1);
        chk("R3 0x09 restores ADR=1 gate", 80'(ready), 80'd0);

        // R4 bit order, R6 freeze, R7 read done
        f = mk(4'd1);
        load(f, 1'b1);
        g = mk(4'd1);
        read80(got, 1'b1, g);
        chk("R4 R6 serial bits of frozen frame", got, f);
        chk("R6 ready held during read", 80'(ready), 80'd1);
        done();
        chk("R7 ready low after read_done", 80'(ready), 80'd0);
        chk("R6 frame during read dropped", 80'(ready), 80'd0);
        f = mk(4'd1);
        load(f, 1'b1);
        chk("R7 capture re-enabled", 80'(ready), 80'd1);
        read80(got, 1'b0, '0);
        chk("R4 bit order second frame", got, f);
        done();

        // R8 timeout
        f = mk(4'd1);
        load(f, 1'b1);
        repeat (HOLD - 1) @(negedge clk);
        chk("R8 ready held through window", 80'(ready), 80'd1);
        @(negedge clk);
        chk("R8 ready timed out", 80'(ready), 80'd0);
        // R5 edge while ready low ignored
        pulse_shift();
        chk("R5 edge ignored while not ready", 80'(sdo), 80'(f[0]));
        load(f, 1'b1);
        repeat (20) @(negedge clk);
        g = mk(4'd1);
        load(g, 1'b1);
        repeat (29) @(negedge clk);
        chk("R8 reload restarts window", 80'(ready), 80'd1);
        repeat (11) @(negedge clk);
        chk("R8 restarted window expires", 80'(ready), 80'd0);

        // R9 chip select, R5 cs gating
        f = mk(4'd1);
        load(f, 1'b1);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R9 oe low with cs high", 80'(sdo_oe), 80'd0);
        chk("R9 sdo zero with cs high", 80'(sdo), 80'd0);
        pulse_shift();
        cs_n = 1'b0;
        @(negedge clk);
        chk("R9 oe high with cs low", 80'(sdo_oe), 80'd1);
        read80(got, 1'b0, '0);
        chk("R5 edges with cs high ignored", got, f);
        done();

        // random phase
        free_mode = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if ($urandom % 3 == 0) begin
                free_mode = $urandom % 2;
                cmd(free_mode ? 8'h89 : 8'h09);
            end
            f = mk(($urandom % 2) ? 4'd1 : 4'($urandom));
            crc = ($urandom % 4) != 0;
            load(f, crc);
            chk("R2 R3 random gating", 80'(ready), 80'(qualifies(f, crc, free_mode)));
            if (ready && ($urandom % 2)) begin
                read80(got, 1'b0, '0);
                chk("R4 random readout", got, f);
            end
            done();
        end

        report();
        $finish;
    end
endmodule